// File: doc/BRIEF.md
# Translation Fault Recorder

This block sits beside a page-table walker and keeps the record of translation faults that software reads afterwards. When the walker reports a failed translation, the block builds a status word from the kind of access, the privilege of the requester, the fault type and the table level. It also stores the page-aligned virtual address. If the status word still holds an earlier, unread fault, the new record is marked as an overflow.

The same event also decides what the processor does next. It can raise an instruction-access trap, raise a data-access trap, or let the access complete with read, write and execute permission. The last outcome applies when the no-fault control is set or traps are disabled. A user-mode permission fault that arrives while no-fault is set is dropped entirely.

The CPU reaches both registers through a small read/write port. A read of the status register returns its value and clears it on the same cycle.

Top module: `fault_recorder`

## Requirements
- R1: After a synchronous active-low reset, the status and address registers read zero and trap_ifetch, trap_data and grant_rwx are low.
- R2: A recorded fault with a zero status register leaves status = (idx << 5) | (level << 8) | (type << 2) | 2.
  - Access kinds are flt_access 0 = load, 1 = store, 2 = fetch, and 3 is treated as a load.
  - idx = 4 for a store, plus 2 for a fetch, plus 1 when flt_user is low.
  - Bit 1 marks the address register as valid.
- R3: A recorded fault that finds the status register nonzero first replaces it with 1 (overflow) and then ORs in the R2 fields.
- R4: A recorded fault loads the address register with flt_va with its low PAGE_BITS (12) bits cleared.
- R5: reg_sel selects the status register (0) or the address register (1), and reg_rdata shows the selected register combinationally. A reg_rd of the status register clears it at the next edge. A read of the address register changes nothing.
- R6: A fault recorded in the same cycle as a status read is merged onto zero, so no overflow bit is set.
- R7: With ctl_nofault low and ctl_traps_en high, a recorded fetch fault gives a one-cycle trap_ifetch pulse on the following cycle. Any other recorded fault gives a one-cycle trap_data pulse instead.
- R8: With ctl_nofault high or ctl_traps_en low, a recorded fault raises no trap and gives a one-cycle grant_rwx pulse on the following cycle.
- R9: A fault with flt_user high, ctl_nofault high and type 2 or 3 (permission faults) is ignored. Both registers keep their values and no output pulse follows.
- R10: reg_wr loads reg_wdata into the selected register. A recorded fault in the same cycle takes priority over the write to either register, and a write takes priority over a read-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_valid | input | 1 | Walker reports a fault this cycle |
| flt_access | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| flt_user | input | 1 | Access made in user mode |
| flt_type | input | 3 | Fault type code from the walker |
| flt_level | input | 2 | Table level where the walk stopped |
| flt_va | input | DATA_W | Faulting virtual address |
| ctl_nofault | input | 1 | No-fault mode control |
| ctl_traps_en | input | 1 | Processor traps enabled |
| reg_sel | input | 1 | 0 status register, 1 address register |
| reg_rd | input | 1 | CPU read strobe |
| reg_wr | input | 1 | CPU write strobe |
| reg_wdata | input | DATA_W | CPU write data |
| reg_rdata | output | DATA_W | Selected register value |
| trap_ifetch | output | 1 | Instruction-access trap pulse |
| trap_data | output | 1 | Data-access trap pulse |
| grant_rwx | output | 1 | Access completes with full permission |

## Verification
The bench covers loads, stores and fetches from both user and supervisor mode. This shows that every access-index bit lands in its own position and that fetches alone reach the instruction trap line. Single faults into a cleared register are compared against back-to-back faults and against faults that coincide with a status read, which separates the overflow path from the clear-priority path. Permission faults and translation faults are applied under each combination of no-fault and trap enable, which tells the dropped case apart from the suppressed-but-recorded case. A long stretch of mixed random traffic then drives collisions between writes, reads and faults.

// File: rtl/fault_recorder_pkg.sv
// Package: shared encodings for the fault recorder.
// Assumes the walker encodes permission faults as types 2 and 3.
package fault_recorder_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } access_e;

    localparam int IDX_LSB   = 5;
    localparam int TYPE_LSB  = 2;
    localparam int LVL_LSB   = 8;
    localparam int VALID_BIT = 1;

    localparam logic [2:0] FT_PERM_A = 3'd2;
    localparam logic [2:0] FT_PERM_B = 3'd3;
endpackage

// File: rtl/fault_classify.sv
// Module: fault_classify
// Decides whether a reported fault is dropped, recorded with a trap, or
// recorded with full-permission completion; also forms the access index.
// Assumes all inputs are stable for the cycle; purely combinational.
module fault_classify
    import fault_recorder_pkg::*;
(
    input  logic       flt_valid,
    input  logic [1:0] flt_access,
    input  logic       flt_user,
    input  logic [2:0] flt_type,
    input  logic       ctl_nofault,
    input  logic       ctl_traps_en,
    output logic       record,
    output logic       suppress,
    output logic       is_fetch,
    output logic [2:0] acc_idx
);
    logic perm_fault;
    logic dropped;

    // Classify the fault and build the access index.
    always_comb begin
        perm_fault = (flt_type == FT_PERM_A) || (flt_type == FT_PERM_B);
        dropped    = flt_user && ctl_nofault && perm_fault;
        record     = flt_valid && !dropped;
        suppress   = ctl_nofault || !ctl_traps_en;
        is_fetch   = (flt_access == ACC_FETCH);
        acc_idx    = {flt_access == ACC_STORE, is_fetch, !flt_user};
    end
endmodule

// File: rtl/fault_regs.sv
// Module: fault_regs
// Holds the fault status and fault address registers and serves the CPU
// port. Priority per register: recorded fault, then write, then read-clear.
// Assumes DATA_W is wide enough for the status fields (at least 10 bits).
module fault_regs
    import fault_recorder_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              record,
    input  logic [2:0]        acc_idx,
    input  logic [2:0]        flt_type,
    input  logic [1:0]        flt_level,
    input  logic [DATA_W-1:0] flt_va,
    input  logic              reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] addr_q
);
    localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_BITS) - DATA_W'(1));

    logic              rd_clear;
    logic              wr_status;
    logic              wr_addr;
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] fields;
    logic [DATA_W-1:0] merged;

    // Decode port strobes and form the merged status word.
    always_comb begin
        rd_clear  = reg_rd && !reg_sel;
        wr_status = reg_wr && !reg_sel;
        wr_addr   = reg_wr && reg_sel;
        base      = rd_clear ? '0 : status_q;
        fields    = (DATA_W'(acc_idx) << IDX_LSB) | (DATA_W'(flt_level) << LVL_LSB)
                  | (DATA_W'(flt_type) << TYPE_LSB) | (DATA_W'(1) << VALID_BIT);
        merged    = ((base != '0) ? DATA_W'(1) : '0) | fields;
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n)         status_q <= '0;
        else if (record)    status_q <= merged;
        else if (wr_status) status_q <= reg_wdata;
        else if (rd_clear)  status_q <= '0;
    end

    // Address register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (record)  addr_q <= flt_va & PAGE_MASK;
        else if (wr_addr) addr_q <= reg_wdata;
    end

    // Read mux.
    always_comb reg_rdata = reg_sel ? addr_q : status_q;
endmodule

// File: rtl/trap_pulse.sv
// Module: trap_pulse
// Registers the one-cycle outcome of a recorded fault: instruction trap,
// data trap, or full-permission grant. At most one fires per cycle.
module trap_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic record,
    input  logic suppress,
    input  logic is_fetch,
    output logic trap_ifetch,
    output logic trap_data,
    output logic grant_rwx
);
    // Outcome pulses, valid the cycle after the fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_ifetch <= 1'b0;
            trap_data   <= 1'b0;
            grant_rwx   <= 1'b0;
        end else begin
            trap_ifetch <= record && !suppress && is_fetch;
            trap_data   <= record && !suppress && !is_fetch;
            grant_rwx   <= record && suppress;
        end
    end
endmodule

// File: rtl/fault_recorder.sv
// Module: fault_recorder (top)
// Records translation faults from a walker into status/address registers,
// flags overflow, and decides trap versus no-fault completion.
// Assumes at most one fault report per cycle.
module fault_recorder #(
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic [1:0]        flt_access,
    input  logic              flt_user,
    input  logic [2:0]        flt_type,
    input  logic [1:0]        flt_level,
    input  logic [DATA_W-1:0] flt_va,
    input  logic              ctl_nofault,
    input  logic              ctl_traps_en,
    input  logic              reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              trap_ifetch,
    output logic              trap_data,
    output logic              grant_rwx
);
    logic              record;
    logic              suppress;
    logic              is_fetch;
    logic [2:0]        acc_idx;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] addr_q;

    fault_classify u_cls (
        .flt_valid   (flt_valid),
        .flt_access  (flt_access),
        .flt_user    (flt_user),
        .flt_type    (flt_type),
        .ctl_nofault (ctl_nofault),
        .ctl_traps_en(ctl_traps_en),
        .record      (record),
        .suppress    (suppress),
        .is_fetch    (is_fetch),
        .acc_idx     (acc_idx)
    );

    fault_regs #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .record   (record),
        .acc_idx  (acc_idx),
        .flt_type (flt_type),
        .flt_level(flt_level),
        .flt_va   (flt_va),
        .reg_sel  (reg_sel),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .status_q (status_q),
        .addr_q   (addr_q)
    );

    trap_pulse u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .record     (record),
        .suppress   (suppress),
        .is_fetch   (is_fetch),
        .trap_ifetch(trap_ifetch),
        .trap_data  (trap_data),
        .grant_rwx  (grant_rwx)
    );
endmodule

// File: rtl/fault_recorder_chk.sv
// Module: fault_recorder_chk
// Temporal checks on the fault recorder, bound to the top module.
module fault_recorder_chk #(
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flt_valid,
    input logic [1:0]        flt_access,
    input logic              flt_user,
    input logic [2:0]        flt_type,
    input logic [DATA_W-1:0] flt_va,
    input logic              ctl_nofault,
    input logic              ctl_traps_en,
    input logic              reg_sel,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic              trap_ifetch,
    input logic              trap_data,
    input logic              grant_rwx,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] addr_q
);
    // R7
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_ifetch, trap_data, grant_rwx}));

    // R7
    ifetch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ifetch |-> $past(flt_valid) && $past(flt_access) == 2'd2
                        && !$past(ctl_nofault) && $past(ctl_traps_en));

    // R8
    grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_rwx |-> $past(flt_valid) && ($past(ctl_nofault) || !$past(ctl_traps_en)));

    // R4
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ifetch || trap_data || grant_rwx) |->
            (addr_q >> PAGE_BITS) == ($past(flt_va) >> PAGE_BITS)
            && addr_q[PAGE_BITS-1:0] == '0 && status_q[1]);

    // R9
    dropped_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flt_valid) && $past(flt_user) && $past(ctl_nofault)
         && ($past(flt_type) == 3'd2 || $past(flt_type) == 3'd3))
        |-> !(trap_ifetch || trap_data || grant_rwx));

    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_sel && !reg_wr && !flt_valid) |=> status_q == '0);
endmodule

bind fault_recorder fault_recorder_chk #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flt_valid   (flt_valid),
    .flt_access  (flt_access),
    .flt_user    (flt_user),
    .flt_type    (flt_type),
    .flt_va      (flt_va),
    .ctl_nofault (ctl_nofault),
    .ctl_traps_en(ctl_traps_en),
    .reg_sel     (reg_sel),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .trap_ifetch (trap_ifetch),
    .trap_data   (trap_data),
    .grant_rwx   (grant_rwx),
    .status_q    (status_q),
    .addr_q      (addr_q)
);

// File: tb/fault_recorder_test.sv
module fault_recorder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_valid = 1'b0;
    logic [1:0]  flt_access = 2'd0;
    logic        flt_user = 1'b0;
    logic [2:0]  flt_type = 3'd0;
    logic [1:0]  flt_level = 2'd0;
    logic [31:0] flt_va = 32'd0;
    logic        ctl_nofault = 1'b0;
    logic        ctl_traps_en = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        trap_ifetch, trap_data, grant_rwx;

    always #5 clk = ~clk;

    fault_recorder uut (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_access(flt_access),
        .flt_user(flt_user), .flt_type(flt_type), .flt_level(flt_level),
        .flt_va(flt_va), .ctl_nofault(ctl_nofault), .ctl_traps_en(ctl_traps_en),
        .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trap_ifetch(trap_ifetch), .trap_data(trap_data),
        .grant_rwx(grant_rwx)
    );

    // Behavioural reference state
    int unsigned m_status = 0, m_addr = 0;
    bit m_ti = 0, m_td = 0, m_gr = 0;
    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    int cycles = 0;

    // Reference model: evaluate requirement rules at each edge
    always @(posedge clk) begin
        bit drop, rec, supp, fetch;
        int unsigned idx, prior;
        cycles++;
        if (!rst_n) begin
            m_status = 0; m_addr = 0; m_ti = 0; m_td = 0; m_gr = 0;
        end else begin
            drop  = flt_user && ctl_nofault && (flt_type == 2 || flt_type == 3);
            rec   = flt_valid && !drop;
            supp  = ctl_nofault || !ctl_traps_en;
            fetch = (flt_access == 2);
            idx   = (flt_access == 1 ? 4 : 0) + (fetch ? 2 : 0) + (flt_user ? 0 : 1);
            m_ti  = rec && !supp && fetch;
            m_td  = rec && !supp && !fetch;
            m_gr  = rec && supp;
            if (rec) begin
                prior = (reg_rd && reg_sel == 0) ? 0 : m_status;
                m_status = (prior != 0 ? 1 : 0) | (idx * 32) | (flt_level * 256)
                         | (flt_type * 4) | 2;
                m_addr = flt_va & 32'hFFFF_F000;
            end else begin
                if (reg_wr && reg_sel == 0) m_status = reg_wdata;
                else if (reg_rd && reg_sel == 0) m_status = 0;
                if (reg_wr && reg_sel == 1) m_addr = reg_wdata;
            end
        end
    end

    task automatic cmp(string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        cmp("rdata", reg_rdata, reg_sel ? m_addr : m_status);
        cmp("trap_ifetch", trap_ifetch, m_ti);
        cmp("trap_data", trap_data, m_td);
        cmp("grant_rwx", grant_rwx, m_gr);
    end

    task automatic idle();
        flt_valid = 0; reg_rd = 0; reg_wr = 0;
        @(posedge clk); #1;
    endtask

    task automatic fault(input logic [1:0] acc, input logic usr, input logic [2:0] ty,
                         input logic [1:0] lv, input logic [31:0] va);
        flt_valid = 1; flt_access = acc; flt_user = usr; flt_type = ty;
        flt_level = lv; flt_va = va;
        @(posedge clk); #1;
        flt_valid = 0;
    endtask

    task automatic rd(input logic sel);
        reg_sel = sel; reg_rd = 1;
        @(posedge clk); #1;
        reg_rd = 0;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_sel = sel; reg_wr = 1; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    // Watchdog
    always @(posedge clk) if (cycles > 20000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        idle(); idle();
        cur_req = "R2";                    // supervisor load, clean register
        fault(2'd0, 0, 3'd1, 2'd2, 32'h1234_5ABC);
        idle();
        cur_req = "R4"; reg_sel = 1; idle(); reg_sel = 0;
        cur_req = "R3";                    // second fault without read
        fault(2'd1, 1, 3'd4, 2'd1, 32'hCAFE_0FFF);
        idle();
        cur_req = "R5"; rd(1); idle(); rd(0); idle(); idle();
        cur_req = "R6";                    // fault collides with read
        fault(2'd0, 1, 3'd1, 2'd0, 32'h0000_1000);
        reg_sel = 0; reg_rd = 1; flt_valid = 1; flt_access = 2'd1;
        @(posedge clk); #1; reg_rd = 0; flt_valid = 0;
        idle(); rd(0);
        cur_req = "R7";
        fault(2'd2, 0, 3'd1, 2'd3, 32'h8000_0000); idle(); rd(0);
        fault(2'd3, 1, 3'd4, 2'd0, 32'h0000_0FFF); idle(); rd(0);
        cur_req = "R8";
        ctl_nofault = 1;
        fault(2'd2, 0, 3'd2, 2'd1, 32'h7777_7777); idle(); rd(0);
        ctl_nofault = 0; ctl_traps_en = 0;
        fault(2'd1, 1, 3'd3, 2'd1, 32'h4444_4444); idle(); rd(0);
        ctl_traps_en = 1;
        cur_req = "R9";
        wr(0, 32'h0000_0055); wr(1, 32'h0000_AAAA);
        ctl_nofault = 1;
        fault(2'd1, 1, 3'd2, 2'd2, 32'hDEAD_BEEF);
        fault(2'd0, 1, 3'd3, 2'd2, 32'hBEEF_DEAD);
        idle(); reg_sel = 1; idle(); reg_sel = 0; idle();
        fault(2'd0, 1, 3'd1, 2'd2, 32'hBEEF_DEAD); idle(); rd(0);
        ctl_nofault = 0;
        cur_req = "R10";
        wr(0, 32'h0BAD_F00D); wr(1, 32'h1357_9BDF); reg_sel = 1; idle(); rd(0);
        reg_sel = 1; reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; flt_valid = 1;
        flt_access = 0; flt_user = 0; flt_type = 3'd1; flt_va = 32'h2222_3333;
        @(posedge clk); #1; reg_wr = 0; flt_valid = 0; idle();
        reg_sel = 0; reg_wr = 1; reg_rd = 1; reg_wdata = 32'h0000_0F0F;
        @(posedge clk); #1; reg_wr = 0; reg_rd = 0; idle();
        cur_req = "R3";                    // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            flt_valid = ($urandom % 3) == 0;
            flt_access = 2'($urandom); flt_user = 1'($urandom);
            flt_type = 3'($urandom); flt_level = 2'($urandom); flt_va = $urandom;
            ctl_nofault = ($urandom % 4) == 0; ctl_traps_en = ($urandom % 4) != 0;
            reg_sel = 1'($urandom); reg_rd = ($urandom % 3) == 0;
            reg_wr = ($urandom % 5) == 0; reg_wdata = $urandom;
            @(posedge clk); #1;
        end
        idle();
        cur_req = "R1";
        rst_n = 0; idle(); rst_n = 1; idle();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule